// File: doc/BRIEF.md
# Segment Access Permission Checker

This block rules on whether one memory access, already mapped to a segment, may proceed. Each request carries the upper flag bits of the selected segment register, the low nibble of that register, the privilege level, the access kind (load, store or instruction fetch), a category for data accesses, the 2-bit page protection field and the effective address. Exactly one clock edge after the request, the block presents the granted read/write/execute rights, an allow flag, a fault class with its status word, and the real address for the direct-store cases that bypass translation.

Ordinary segments are judged by a protection table that depends on a key. The key is picked from the segment's user or supervisor key bit. A no-execute flag on the segment then removes the execute right. Segments marked as direct-store follow their own rules. A reserved bus-unit number opens a forced memory window with full rights, and outside that window the outcome depends on the category of the access. The table walk and the address translation itself belong to neighbouring logic.

The control is a two-state machine. `ST_IDLE` is left for `ST_SHOW` on the transition *accept*, which fires on any cycle with `req_valid` high. `ST_SHOW` stays in `ST_SHOW` on *chain*, when another request arrives, and returns to `ST_IDLE` on *drain*, when none does. `out_valid` is high exactly in `ST_SHOW`. Result registers load only on *accept* or *chain*, so they hold their values while the machine is idle.

Top module: `segperm_check`

## Requirements
- R1: The key is `seg_flags[9]` when `user_mode` is 1 and `seg_flags[10]` when `user_mode` is 0. `seg_flags[11:0]` carries segment bits 31:20: bit 11 is the direct-store flag, bit 8 is no-execute, and bits 8:0 are the bus-unit number.
- R2: In a segment with the direct-store flag clear and key 0, protection values 0, 1 and 2 grant read and write, and value 3 grants read only. `rights` is {read, write, execute} from bit 2 down to bit 0.
- R3: In a segment with the direct-store flag clear and key 1, protection value 2 grants read and write, values 1 and 3 grant read only, and value 0 grants nothing.
- R4: In a segment with the direct-store flag clear, execute is granted exactly when no-execute is clear. A fetch from a no-execute segment faults as instruction (fault class 1) with status 0x10000000, whatever the protection value.
- R5: A load, store or fetch lacks its right when it does not have read, write or execute respectively. That access is refused. A fetch reports class 1 with status 0x08000000. A store reports data fault (class 2) with 0x0A000000. A load reports class 2 with 0x08000000. An allowed access reports class 0 and status 0.
- R6: In a direct-store segment whose bus-unit number is 0x07F, every access is allowed with rights 3'b111, and `real_addr` is `seg_page` followed by `eff_addr[27:0]`. In every other case `real_addr` equals `eff_addr`.
- R7: In any other direct-store segment, a fetch faults with class 1 and status 0x10000000. A floating-point access (category 1) faults as alignment (class 3) with status 0.
- R8: In such segments, an external-control access (category 4) faults with class 2, status 0x06100000 for a store and 0x04100000 for a load. A cache-management access (category 3) is allowed with rights 3'b000.
- R9: In such segments, a reservation access (category 2) faults with class 2, status 0x06000000 for a store and 0x04000000 for a load.
- R10: In such segments, an integer access (category 0) is allowed for a load only when the key is 1 and for a store only when the key is 0. Otherwise it faults with class 2, status 0x0A000000 for a store and 0x08000000 for a load. Direct-store segments always report rights 3'b000 outside the 0x07F window.
- R11: An access kind of 3 or a category above 4 takes priority over all other rules. `req_error` is set, the fault is class 4, `allow` is 0, rights are 3'b000 and status is 0.
- R12: After reset every output is zero. Results appear with `out_valid` on the cycle after `req_valid`, and they hold unchanged while no request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| seg_flags | input | 12 | Segment register bits 31:20 |
| seg_page | input | 4 | Segment register bits 3:0 |
| user_mode | input | 1 | 1 for a user access, 0 for a privileged one |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 undefined |
| acc_cat | input | 3 | 0 integer, 1 float, 2 reservation, 3 cache, 4 external, 5-7 undefined |
| prot_pp | input | 2 | Page protection value |
| eff_addr | input | EA_W | Effective address |
| out_valid | output | 1 | Result registers hold a fresh result |
| allow | output | 1 | Access permitted |
| rights | output | 3 | Granted {read, write, execute} |
| fault_class | output | 3 | 0 none, 1 instruction, 2 data, 3 alignment, 4 bad request |
| status_code | output | 32 | Fault status word |
| real_addr | output | EA_W | Real address |
| req_error | output | 1 | Undefined kind or category |

## Verification
The checker is swept over every combination of privilege, both key bits, no-execute, all four protection values and all three access kinds in ordinary segments. A wrong key choice, a swapped table row or a missed execute mask therefore each shows up as a distinct mismatch. Direct-store segments are driven with every category and kind under both keys. This separates the forced window from the per-category rules, and the store statuses from the load statuses. Undefined kinds and categories are applied to both segment types to confirm their priority. Idle gaps between requests show that the result registers hold their values.

// File: rtl/segperm_pkg.sv
package segperm_pkg;

    localparam int STATUS_W = 32;
    localparam int RIGHTS_W = 3;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_BAD   = 2'd3
    } kind_e;

    localparam logic [2:0] CAT_INT   = 3'd0;
    localparam logic [2:0] CAT_FLOAT = 3'd1;
    localparam logic [2:0] CAT_RESV  = 3'd2;
    localparam logic [2:0] CAT_CACHE = 3'd3;
    localparam logic [2:0] CAT_EXT   = 3'd4;
    localparam logic [2:0] CAT_LAST  = CAT_EXT;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_INSN   = 3'd1,
        FLT_DATA   = 3'd2,
        FLT_ALIGN  = 3'd3,
        FLT_BADREQ = 3'd4
    } fault_e;

    localparam logic [RIGHTS_W-1:0] RGT_R    = 3'b100;
    localparam logic [RIGHTS_W-1:0] RGT_W    = 3'b010;
    localparam logic [RIGHTS_W-1:0] RGT_X    = 3'b001;
    localparam logic [RIGHTS_W-1:0] RGT_NONE = 3'b000;
    localparam logic [RIGHTS_W-1:0] RGT_ALL  = 3'b111;

    localparam logic [STATUS_W-1:0] ST_OK          = 32'h0000_0000;
    localparam logic [STATUS_W-1:0] ST_NOEXEC      = 32'h1000_0000;
    localparam logic [STATUS_W-1:0] ST_PROT_LOAD   = 32'h0800_0000;
    localparam logic [STATUS_W-1:0] ST_PROT_STORE  = 32'h0A00_0000;
    localparam logic [STATUS_W-1:0] ST_RESV_LOAD   = 32'h0400_0000;
    localparam logic [STATUS_W-1:0] ST_RESV_STORE  = 32'h0600_0000;
    localparam logic [STATUS_W-1:0] ST_EXT_LOAD    = 32'h0410_0000;
    localparam logic [STATUS_W-1:0] ST_EXT_STORE   = 32'h0610_0000;

    typedef struct packed {
        logic                 allow;
        logic [RIGHTS_W-1:0]  rights;
        fault_e               fault;
        logic [STATUS_W-1:0]  status;
    } verdict_t;

endpackage

// File: rtl/segperm_rights.sv
module segperm_rights
    import segperm_pkg::*;
(
    input  logic                key,
    input  logic [1:0]          pp,
    input  logic                nx,
    output logic [RIGHTS_W-1:0] rights
);

    logic [RIGHTS_W-1:0] data_rights;

    // Key-dependent data rights; execute is added from the segment flag.
    always_comb begin
        unique case ({key, pp})
            3'b0_00: data_rights = RGT_R | RGT_W;
            3'b0_01: data_rights = RGT_R | RGT_W;
            3'b0_10: data_rights = RGT_R | RGT_W;
            3'b0_11: data_rights = RGT_R;
            3'b1_00: data_rights = RGT_NONE;
            3'b1_01: data_rights = RGT_R;
            3'b1_10: data_rights = RGT_R | RGT_W;
            3'b1_11: data_rights = RGT_R;
            default: data_rights = RGT_NONE;
        endcase
        rights = data_rights | (nx ? RGT_NONE : RGT_X);
    end

endmodule

// File: rtl/segperm_xlate.sv
module segperm_xlate
    import segperm_pkg::*;
(
    input  kind_e      kind,
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       nx,
    output verdict_t   verdict
);

    logic [RIGHTS_W-1:0] granted;
    logic [RIGHTS_W-1:0] needed;

    segperm_rights u_rights (
        .key    (key),
        .pp     (pp),
        .nx     (nx),
        .rights (granted)
    );

    always_comb begin
        unique case (kind)
            KIND_LOAD:  needed = RGT_R;
            KIND_STORE: needed = RGT_W;
            KIND_FETCH: needed = RGT_X;
            default:    needed = RGT_NONE;
        endcase
    end

    always_comb begin
        verdict.rights = granted;
        verdict.allow  = 1'b0;
        verdict.fault  = FLT_NONE;
        verdict.status = ST_OK;
        if (kind == KIND_FETCH && nx) begin
            verdict.fault  = FLT_INSN;
            verdict.status = ST_NOEXEC;
        end else if ((needed & ~granted) != RGT_NONE) begin
            unique case (kind)
                KIND_FETCH: begin
                    verdict.fault  = FLT_INSN;
                    verdict.status = ST_PROT_LOAD;
                end
                KIND_STORE: begin
                    verdict.fault  = FLT_DATA;
                    verdict.status = ST_PROT_STORE;
                end
                default: begin
                    verdict.fault  = FLT_DATA;
                    verdict.status = ST_PROT_LOAD;
                end
            endcase
        end else begin
            verdict.allow = 1'b1;
        end
    end

endmodule

// File: rtl/segperm_dstore.sv
module segperm_dstore
    import segperm_pkg::*;
#(
    parameter logic [8:0] FORCED_BUID = 9'h07F
) (
    input  logic [8:0] buid,
    input  kind_e      kind,
    input  logic [2:0] cat,
    input  logic       key,
    output verdict_t   verdict
);

    logic is_store;
    assign is_store = (kind == KIND_STORE);

    always_comb begin
        verdict.allow  = 1'b0;
        verdict.rights = RGT_NONE;
        verdict.fault  = FLT_NONE;
        verdict.status = ST_OK;
        if (buid == FORCED_BUID) begin
            verdict.allow  = 1'b1;
            verdict.rights = RGT_ALL;
        end else if (kind == KIND_FETCH) begin
            verdict.fault  = FLT_INSN;
            verdict.status = ST_NOEXEC;
        end else begin
            unique case (cat)
                CAT_INT: begin
                    if (is_store ? !key : key) begin
                        verdict.allow = 1'b1;
                    end else begin
                        verdict.fault  = FLT_DATA;
                        verdict.status = is_store ? ST_PROT_STORE : ST_PROT_LOAD;
                    end
                end
                CAT_FLOAT: verdict.fault = FLT_ALIGN;
                CAT_RESV: begin
                    verdict.fault  = FLT_DATA;
                    verdict.status = is_store ? ST_RESV_STORE : ST_RESV_LOAD;
                end
                CAT_CACHE: verdict.allow = 1'b1;
                CAT_EXT: begin
                    verdict.fault  = FLT_DATA;
                    verdict.status = is_store ? ST_EXT_STORE : ST_EXT_LOAD;
                end
                default: verdict.fault = FLT_BADREQ;
            endcase
        end
    end

endmodule

// File: rtl/segperm_check.sv
module segperm_check
    import segperm_pkg::*;
#(
    parameter int         EA_W        = 32,
    parameter logic [8:0] FORCED_BUID = 9'h07F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [11:0]         seg_flags,
    input  logic [3:0]          seg_page,
    input  logic                user_mode,
    input  logic [1:0]          acc_kind,
    input  logic [2:0]          acc_cat,
    input  logic [1:0]          prot_pp,
    input  logic [EA_W-1:0]     eff_addr,
    output logic                out_valid,
    output logic                allow,
    output logic [2:0]          rights,
    output logic [2:0]          fault_class,
    output logic [31:0]         status_code,
    output logic [EA_W-1:0]     real_addr,
    output logic                req_error
);

    localparam int PAGE_W = 4;
    localparam int LOW_W  = EA_W - PAGE_W;

    typedef enum logic {ST_IDLE = 1'b0, ST_SHOW = 1'b1} state_e;

    state_e    state_q, state_d;
    kind_e     kind;
    logic      ds_flag, nx_flag, key, bad_req, forced;
    verdict_t  xl_v, ds_v, pick_v;
    logic [EA_W-1:0] addr_d;

    assign kind    = kind_e'(acc_kind);
    assign ds_flag = seg_flags[11];
    assign nx_flag = seg_flags[8];
    assign key     = user_mode ? seg_flags[9] : seg_flags[10];
    assign bad_req = (kind == KIND_BAD) || (acc_cat > CAT_LAST);
    assign forced  = ds_flag && (seg_flags[8:0] == FORCED_BUID);
    assign addr_d  = forced ? {seg_page, eff_addr[LOW_W-1:0]} : eff_addr;

    segperm_xlate u_xlate (
        .kind    (kind),
        .key     (key),
        .pp      (prot_pp),
        .nx      (nx_flag),
        .verdict (xl_v)
    );

    segperm_dstore #(.FORCED_BUID(FORCED_BUID)) u_dstore (
        .buid    (seg_flags[8:0]),
        .kind    (kind),
        .cat     (acc_cat),
        .key     (key),
        .verdict (ds_v)
    );

    always_comb begin
        if (bad_req) begin
            pick_v.allow  = 1'b0;
            pick_v.rights = RGT_NONE;
            pick_v.fault  = FLT_BADREQ;
            pick_v.status = ST_OK;
        end else if (ds_flag) begin
            pick_v = ds_v;
        end else begin
            pick_v = xl_v;
        end
    end

    // Next-state logic: accept/chain on a request, drain otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow       <= 1'b0;
            rights      <= RGT_NONE;
            fault_class <= 3'd0;
            status_code <= ST_OK;
            real_addr   <= '0;
            req_error   <= 1'b0;
        end else if (state_d == ST_SHOW) begin
            allow       <= pick_v.allow;
            rights      <= pick_v.rights;
            fault_class <= pick_v.fault;
            status_code <= pick_v.status;
            real_addr   <= addr_d;
            req_error   <= bad_req;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    AST_OUT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R12
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(status_code) && $stable(allow))); // R12
    AST_ALLOW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && allow) |-> (fault_class == 3'd0 && status_code == 32'd0)); // R5
    AST_NX_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_flags[11] && seg_flags[8]) |=> !rights[0]); // R4
    AST_BADCAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_cat > 3'd4) |=> (req_error && !allow)); // R11
    AST_FORCED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_flags[11] && seg_flags[8:0] == FORCED_BUID
         && acc_kind != 2'd3 && acc_cat <= 3'd4) |=> (allow && rights == 3'b111)); // R6
    AST_DS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_flags[11] && seg_flags[8:0] != FORCED_BUID
         && acc_kind == 2'd2 && acc_cat <= 3'd4)
        |=> (fault_class == 3'd1 && status_code == 32'h1000_0000)); // R7

endmodule

// File: tb/sim_segperm_check.sv
module sim_segperm_check;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    typedef struct {
        logic        allow;
        logic [2:0]  rights;
        logic [2:0]  fault;
        logic [31:0] status;
        logic [31:0] raddr;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] seg_flags = '0;
    logic [3:0]  seg_page = '0;
    logic        user_mode = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  acc_cat = '0;
    logic [1:0]  prot_pp = '0;
    logic [31:0] eff_addr = '0;
    logic        out_valid, allow, req_error;
    logic [2:0]  rights, fault_class;
    logic [31:0] status_code, real_addr;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    exp_t q[$];
    exp_t last;
    bit   have_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    segperm_check u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_flags(seg_flags),
        .seg_page(seg_page), .user_mode(user_mode), .acc_kind(acc_kind),
        .acc_cat(acc_cat), .prot_pp(prot_pp), .eff_addr(eff_addr),
        .out_valid(out_valid), .allow(allow), .rights(rights),
        .fault_class(fault_class), .status_code(status_code),
        .real_addr(real_addr), .req_error(req_error)
    );

    // Reference model written from the requirement list.
    function automatic exp_t model(logic [11:0] f, logic [3:0] pg, logic [31:0] ea,
                                   logic usr, logic [1:0] kd, logic [2:0] ct,
                                   logic [1:0] pp);
        exp_t e;
        logic key, rd, wr, ex, have;
        key = usr ? f[9] : f[10];
        e.raddr = (f[11] && f[8:0] == 9'h07F) ? {pg, ea[27:0]} : ea;
        e.allow = 0; e.rights = 0; e.fault = 0; e.status = 0; e.err = 0;
        if (kd == 2'd3 || ct > 3'd4) begin
            e.err = 1; e.fault = 3'd4; e.tag = "R11";
        end else if (!f[11]) begin
            rd = !(key && pp == 2'd0);
            wr = key ? (pp == 2'd2) : (pp != 2'd3);
            ex = !f[8];
            e.rights = {rd, wr, ex};
            e.tag = key ? "R3" : "R2";
            have = (kd == 2'd0) ? rd : (kd == 2'd1) ? wr : ex;
            if (kd == 2'd2 && f[8]) begin
                e.fault = 3'd1; e.status = 32'h1000_0000; e.tag = "R4";
            end else if (!have) begin
                e.tag = "R5";
                if (kd == 2'd2) begin e.fault = 3'd1; e.status = 32'h0800_0000; end
                else begin e.fault = 3'd2; e.status = (kd == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000; end
            end else e.allow = 1;
        end else if (f[8:0] == 9'h07F) begin
            e.allow = 1; e.rights = 3'b111; e.tag = "R6";
        end else if (kd == 2'd2) begin
            e.fault = 3'd1; e.status = 32'h1000_0000; e.tag = "R7";
        end else begin
            case (ct)
                3'd0: begin
                    e.tag = "R10";
                    if ((kd == 2'd1 && !key) || (kd == 2'd0 && key)) e.allow = 1;
                    else begin e.fault = 3'd2; e.status = (kd == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000; end
                end
                3'd1: begin e.fault = 3'd3; e.tag = "R7"; end
                3'd2: begin e.fault = 3'd2; e.status = (kd == 2'd1) ? 32'h0600_0000 : 32'h0400_0000; e.tag = "R9"; end
                3'd3: begin e.allow = 1; e.tag = "R8"; end
                default: begin e.fault = 3'd2; e.status = (kd == 2'd1) ? 32'h0610_0000 : 32'h0410_0000; e.tag = "R8"; end
            endcase
        end
        return e;
    endfunction

    task automatic send(logic [11:0] f, logic [3:0] pg, logic [31:0] ea, logic usr,
                        logic [1:0] kd, logic [2:0] ct, logic [1:0] pp);
        @(negedge clk);
        seg_flags = f; seg_page = pg; eff_addr = ea; user_mode = usr;
        acc_kind = kd; acc_cat = ct; prot_pp = pp; req_valid = 1'b1;
        q.push_back(model(f, pg, ea, usr, kd, ct, pp));
    endtask

    task automatic pause(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare on each fresh result; check hold when idle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R12: out_valid with nothing expected (actual 1, expected 0)");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (allow !== e.allow || rights !== e.rights || fault_class !== e.fault ||
                        status_code !== e.status || real_addr !== e.raddr || req_error !== e.err) begin
                        bad++;
                        $display("FAIL %s: actual a=%0b r=%b f=%0d s=%h ra=%h e=%0b expected a=%0b r=%b f=%0d s=%h ra=%h e=%0b",
                                 e.tag, allow, rights, fault_class, status_code, real_addr, req_error,
                                 e.allow, e.rights, e.fault, e.status, e.raddr, e.err);
                    end
                    last = e; have_last = 1;
                end
            end else if (have_last) begin
                total++;
                if (allow !== last.allow || status_code !== last.status) begin
                    bad++;
                    $display("FAIL R12: hold actual a=%0b s=%h expected a=%0b s=%h",
                             allow, status_code, last.allow, last.status);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++; // R12 reset state
        if (out_valid !== 0 || allow !== 0 || status_code !== 0 || rights !== 0 || req_error !== 0) begin
            bad++;
            $display("FAIL R12: reset actual v=%0b a=%0b s=%h expected all zero", out_valid, allow, status_code);
        end

        // R1 R2 R3 R4 R5: ordinary segments, full sweep
        for (int u = 0; u < 2; u++)
            for (int ks = 0; ks < 2; ks++)
                for (int kp = 0; kp < 2; kp++)
                    for (int nx = 0; nx < 2; nx++)
                        for (int pp = 0; pp < 4; pp++)
                            for (int kd = 0; kd < 3; kd++)
                                send({1'b0, ks[0], kp[0], nx[0], 8'h5A}, 4'h3, 32'hC123_4567,
                                     u[0], kd[1:0], 3'd0, pp[1:0]);
        pause(3);

        // R6: forced window, every kind and category
        for (int kd = 0; kd < 3; kd++)
            for (int ct = 0; ct < 5; ct++)
                send({3'b100, 9'h07F}, 4'hB, 32'h7654_3210, kd[0], kd[1:0], ct[2:0], 2'd0);
        pause(2);

        // R7 R8 R9 R10: other direct-store segments
        for (int u = 0; u < 2; u++)
            for (int ks = 0; ks < 2; ks++)
                for (int kd = 0; kd < 3; kd++)
                    for (int ct = 0; ct < 5; ct++)
                        send({1'b1, ks[0], ~ks[0], 9'h012}, 4'h9, 32'h1357_9BDF,
                             u[0], kd[1:0], ct[2:0], 2'd3);
        pause(2);

        // R11: undefined kind or category in both segment types
        for (int ct = 0; ct < 8; ct++) begin
            send({1'b0, 3'b000, 8'h00}, 4'h1, 32'h0000_1000, 1'b0, 2'd3, ct[2:0], 2'd1);
            send({3'b100, 9'h07F}, 4'h2, 32'h0000_2000, 1'b1, 2'd0, ct[2:0], 2'd1);
            send({3'b100, 9'h033}, 4'h2, 32'h0000_3000, 1'b1, 2'd1, ct[2:0], 2'd1);
        end
        pause(4);

        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL R12: actual %0d results missing expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule